// File: doc/BRIEF.md
# Reset-addressed dual-clock field memory

This block is a serial field store for 12-bit video words. It has one write port and one read port, and each port runs on its own clock. The two clocks need not be related, and they may run at different rates. Each port keeps its own address counter. That counter moves forward by one on every enabled access and returns to zero only when the port's restart strobe is applied, or when it passes the last location. There are no full or empty flags, and no pointer crosses between the clock domains.

In use, the block acts as a digital delay line. The write side is restarted at the top of a field. The read side is restarted some number of accesses later, and the words come out delayed by exactly that offset. The first `LINE_WORDS` locations sit in a separate head bank that both ports reach directly. A restart therefore costs no extra cycle: an enabled write on the restart edge lands in location zero, and an enabled read on the restart edge presents location zero on the next output update. Either clock may be halted at any level for any length of time. The stored words, both addresses and the output register keep their values while a clock is halted. The output is registered in the read clock domain, so one block's output can drive the next block's data input directly to build a longer delay.

Top module: `fm_field_mem`

## Requirements
- R1: After the read-side reset, `rd_data` is zero. After both resets, the first enabled write with no restart goes to location 0, and the first enabled read with no restart returns location 0.
- R2: On a write clock edge with `wr_en` high, `wr_data` is stored at the write address and the address advances by one. With `wr_en` low, nothing is stored and the address holds.
- R3: On a read clock edge with `rd_en` high, `rd_data` takes the word at the read address and the address advances by one. With `rd_en` low, `rd_data` and the address hold.
- R4: `wr_restart` together with `wr_en` on the same edge writes location 0, and the next write goes to location 1. `wr_restart` alone sets the write address to 0 and stores nothing.
- R5: `rd_restart` together with `rd_en` on the same edge puts location 0 on `rd_data` after that edge, with no added cycle, and the next read is location 1. `rd_restart` alone sets the read address to 0 and leaves `rd_data` unchanged.
- R6: Without a restart, each address wraps from `DEPTH-1` to 0, and a second pass overwrites or rereads the same locations.
- R7: If the read restart comes N enabled writes after the write restart, and the two ports then advance once each per step, then read step j returns the word written at write step j.
- R8: Halting either clock at any level for any time loses no stored word, no address and no output value. Accesses resume from the saved addresses when the clock restarts.
- R9: Words at the last head-bank location (`LINE_WORDS-1`) and the first body location (`LINE_WORDS`) read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_rst | input | 1 | Synchronous active-high reset of the write port |
| wr_en | input | 1 | Write enable |
| wr_restart | input | 1 | Return the write address to zero |
| wr_data | input | 12 | Write data |
| rd_clk | input | 1 | Read port clock |
| rd_rst | input | 1 | Synchronous active-high reset of the read port |
| rd_en | input | 1 | Read enable |
| rd_restart | input | 1 | Return the read address to zero |
| rd_data | output | 12 | Registered read data |

## Verification
The bound checker watches each port's address counter on every edge of that port's own clock. It checks that the address holds when the port is idle, steps by one with a wrap when enabled, and lands on 0 or 1 after a restart. It also checks that the output register holds while reads are disabled and that both addresses stay inside the array. Whether the stored words are correct can only be shown by the bench scenarios. These cover delay-line timing set by the restart offset, wrap overwrite, the head/body boundary, and clocks halted and resumed at unrelated rates. The bench compares these results against its own model of the array.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
    localparam int WORD_W = 12;
    localparam int ADDR_W = 18;  // covers the nominal 256K-word field

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t data;
    } wr_req_t;

    // Step an address by one, wrapping after depth-1.
    function automatic addr_t fm_next(addr_t a, int unsigned depth);
        if (a >= addr_t'(depth - 1)) return '0;
        return a + addr_t'(1);
    endfunction

    // Address used on this edge: zero on restart, else the counter.
    function automatic addr_t fm_target(addr_t cur, logic restart);
        return restart ? '0 : cur;
    endfunction
endpackage

// File: rtl/fm_wr_port.sv
`timescale 1ns/1ps
module fm_wr_port
    import fm_pkg::*;
#(
    parameter int unsigned DEPTH = 1024
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    restart,
    input  word_t   din,
    output wr_req_t req,
    output addr_t   addr
);
    addr_t addr_q;
    addr_t tgt;

    always_comb begin
        tgt      = fm_target(addr_q, restart);
        req.we   = en;
        req.addr = tgt;
        req.data = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (en) begin
            addr_q <= fm_next(tgt, DEPTH);
        end else if (restart) begin
            addr_q <= '0;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/fm_rd_port.sv
`timescale 1ns/1ps
module fm_rd_port
    import fm_pkg::*;
#(
    parameter int unsigned DEPTH = 1024
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  restart,
    output addr_t look_addr,
    input  word_t look_data,
    output word_t dout,
    output addr_t addr
);
    addr_t addr_q;
    word_t dout_q;

    always_comb look_addr = fm_target(addr_q, restart);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            dout_q <= '0;
        end else if (en) begin
            dout_q <= look_data;
            addr_q <= fm_next(look_addr, DEPTH);
        end else if (restart) begin
            addr_q <= '0;
        end
    end

    assign dout = dout_q;
    assign addr = addr_q;
endmodule

// File: rtl/fm_store.sv
`timescale 1ns/1ps
module fm_store
    import fm_pkg::*;
#(
    parameter int unsigned DEPTH      = 1024,
    parameter int unsigned LINE_WORDS = 256
) (
    input  logic    wr_clk,
    input  wr_req_t req,
    input  addr_t   rd_addr,
    output word_t   rd_word
);
    localparam int unsigned HEAD    = (LINE_WORDS < DEPTH) ? LINE_WORDS : DEPTH;
    localparam int unsigned BODY    = DEPTH - HEAD;
    localparam int unsigned HEAD_AW = (HEAD > 1) ? $clog2(HEAD) : 1;
    localparam int unsigned BODY_AW = (BODY > 1) ? $clog2(BODY) : 1;
    localparam addr_t       HEAD_A  = addr_t'(HEAD);

    // Head bank: the line buffer that serves the first words after a restart.
    word_t head_q [HEAD];
    word_t head_rd;
    word_t body_rd;

    always_ff @(posedge wr_clk) begin
        if (req.we && (req.addr < HEAD_A)) begin
            head_q[req.addr[HEAD_AW-1:0]] <= req.data;
        end
    end

    assign head_rd = head_q[rd_addr[HEAD_AW-1:0]];

    generate
        if (BODY > 0) begin : g_body
            word_t body_q [BODY];
            addr_t w_off;
            addr_t r_off;

            assign w_off = req.addr - HEAD_A;
            assign r_off = rd_addr - HEAD_A;

            always_ff @(posedge wr_clk) begin
                if (req.we && (req.addr >= HEAD_A)) begin
                    body_q[w_off[BODY_AW-1:0]] <= req.data;
                end
            end

            assign body_rd = body_q[r_off[BODY_AW-1:0]];
        end else begin : g_nobody
            assign body_rd = '0;
        end
    endgenerate

    assign rd_word = (rd_addr < HEAD_A) ? head_rd : body_rd;
endmodule

// File: rtl/fm_field_mem.sv
`timescale 1ns/1ps
module fm_field_mem
    import fm_pkg::*;
#(
    parameter int unsigned DEPTH      = 1024,
    parameter int unsigned LINE_WORDS = 256
) (
    input  logic        wr_clk,
    input  logic        wr_rst,
    input  logic        wr_en,
    input  logic        wr_restart,
    input  logic [11:0] wr_data,
    input  logic        rd_clk,
    input  logic        rd_rst,
    input  logic        rd_en,
    input  logic        rd_restart,
    output logic [11:0] rd_data
);
    wr_req_t req;
    addr_t   wr_addr;
    addr_t   rd_addr;
    addr_t   look_addr;
    word_t   look_word;
    word_t   dout;

    fm_wr_port #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .en(wr_en), .restart(wr_restart),
        .din(wr_data), .req(req), .addr(wr_addr)
    );

    fm_store #(.DEPTH(DEPTH), .LINE_WORDS(LINE_WORDS)) u_store (
        .wr_clk(wr_clk), .req(req), .rd_addr(look_addr), .rd_word(look_word)
    );

    fm_rd_port #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .en(rd_en), .restart(rd_restart),
        .look_addr(look_addr), .look_data(look_word), .dout(dout), .addr(rd_addr)
    );

    assign rd_data = dout;
endmodule

// File: rtl/fm_field_mem_chk.sv
`timescale 1ns/1ps
module fm_field_mem_chk
    import fm_pkg::*;
#(
    parameter int unsigned DEPTH = 1024
) (
    input logic  wr_clk,
    input logic  wr_rst,
    input logic  wr_en,
    input logic  wr_restart,
    input addr_t wr_addr,
    input logic  rd_clk,
    input logic  rd_rst,
    input logic  rd_en,
    input logic  rd_restart,
    input addr_t rd_addr,
    input word_t rd_data
);
    assert_wr_hold_R2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!wr_en && !wr_restart) |=> $stable(wr_addr));

    assert_wr_step_R2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && !wr_restart) |=> (wr_addr == fm_next($past(wr_addr), DEPTH)));

    assert_wr_restart_en_R4: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_restart) |=> (wr_addr == fm_next('0, DEPTH)));

    assert_wr_restart_idle_R4: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!wr_en && wr_restart) |=> (wr_addr == '0));

    assert_rd_hold_R3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_en |=> $stable(rd_data));

    assert_rd_step_R3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && !rd_restart) |=> (rd_addr == fm_next($past(rd_addr), DEPTH)));

    assert_rd_restart_en_R5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_restart) |=> (rd_addr == fm_next('0, DEPTH)));

    assert_rd_restart_idle_R5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!rd_en && rd_restart) |=> (rd_addr == '0));

    assert_wr_range_R6: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_addr < addr_t'(DEPTH));

    assert_rd_range_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_addr < addr_t'(DEPTH));
endmodule

bind fm_field_mem fm_field_mem_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_restart(wr_restart),
    .wr_addr(wr_addr), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .rd_restart(rd_restart), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_fm_field_mem.sv
`timescale 1ns/1ps
module tb_fm_field_mem;
    localparam int D = 96;
    localparam int L = 32;

    logic        wr_clk = 0, rd_clk = 0;
    logic        wr_rst = 1, rd_rst = 1;
    logic        wr_en = 0, wr_restart = 0, rd_en = 0, rd_restart = 0;
    logic [11:0] wr_data = 0;
    logic [11:0] rd_data;

    bit       wr_run = 1, rd_run = 1;
    realtime  rd_half = 2.5;
    int       total = 0, bad = 0;
    bit       done = 0;

    logic [11:0] model [D];
    int          wp = 0, rp = 0;
    logic [11:0] last_out = 0;

    fm_field_mem #(.DEPTH(D), .LINE_WORDS(L)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_restart(wr_restart),
        .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .rd_restart(rd_restart), .rd_data(rd_data)
    );

    always begin #2.5; if (wr_run) wr_clk = ~wr_clk; end
    always begin #(rd_half); if (rd_run) rd_clk = ~rd_clk; end

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_cycle(input logic en, input logic rs, input logic [11:0] d);
        int a;
        @(negedge wr_clk);
        wr_en = en; wr_restart = rs; wr_data = d;
        @(posedge wr_clk); #1;
        wr_en = 0; wr_restart = 0;
        a = rs ? 0 : wp;
        if (en) begin model[a] = d; wp = (a + 1) % D; end
        else if (rs) wp = 0;
    endtask

    task automatic rd_cycle(input logic en, input logic rs, input string tag);
        int a;
        @(negedge rd_clk);
        rd_en = en; rd_restart = rs;
        @(posedge rd_clk); #1;
        rd_en = 0; rd_restart = 0;
        a = rs ? 0 : rp;
        if (en) begin last_out = model[a]; rp = (a + 1) % D; end
        else if (rs) rp = 0;
        chk(tag, rd_data, last_out);
    endtask

    task automatic t_reset();
        chk("R1 output after reset", rd_data, 12'h000);
        wr_cycle(1, 0, 12'hA01);
        wr_cycle(1, 0, 12'hA02);
        rd_cycle(1, 0, "R1 first read");
        chk("R1 first read is location 0", rd_data, 12'hA01);
        rd_cycle(1, 0, "R1 second read");
        chk("R1 second read", rd_data, 12'hA02);
    endtask

    task automatic t_enable_gate();
        wr_cycle(1, 1, 12'h111);
        wr_cycle(0, 0, 12'hBAD);
        wr_cycle(0, 0, 12'hBAD);
        wr_cycle(1, 0, 12'h222);
        rd_cycle(1, 1, "R2 read after gated writes");
        chk("R2 location 0", rd_data, 12'h111);
        rd_cycle(0, 0, "R3 hold");
        chk("R3 held while disabled", rd_data, 12'h111);
        rd_cycle(1, 0, "R2 next location");
        chk("R2 disabled writes skipped", rd_data, 12'h222);
    endtask

    task automatic t_restart_idle();
        wr_cycle(1, 1, 12'h333);
        wr_cycle(1, 0, 12'h344);
        wr_cycle(0, 1, 12'hBAD);
        wr_cycle(1, 0, 12'h355);
        rd_cycle(1, 0, "R5 pre");
        rd_cycle(0, 1, "R5 restart alone holds output");
        rd_cycle(1, 0, "R4 restart alone then write at 0");
        chk("R4 location 0 rewritten", rd_data, 12'h355);
        rd_cycle(1, 0, "R4 location 1 kept");
        chk("R4 location 1", rd_data, 12'h344);
        rd_cycle(1, 1, "R5 restart with enable");
        chk("R5 zero-latency first word", rd_data, 12'h355);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < D + 2; i++) wr_cycle(1, i == 0, 12'(12'h600 + i));
        for (int i = 0; i < D + 2; i++) begin
            rd_cycle(1, i == 0, (i == L - 1 || i == L) ? "R9 bank boundary" : "R6 wrap pass");
            if (i == 0) chk("R6 location 0 overwritten", rd_data, 12'(12'h600 + D));
            if (i == L - 1) chk("R9 last head word", rd_data, 12'(12'h600 + L - 1));
            if (i == L) chk("R9 first body word", rd_data, 12'(12'h600 + L));
            if (i == D) chk("R6 wrapped read", rd_data, 12'(12'h600 + D));
        end
    endtask

    task automatic t_delay();
        localparam int N = 10;
        for (int k = 0; k < N; k++) wr_cycle(1, k == 0, 12'(12'h800 + k));
        for (int j = 0; j < 40; j++) begin
            wr_cycle(1, 0, 12'(12'h800 + N + j));
            rd_cycle(1, j == 0, "R7 delay stream");
            chk("R7 delayed word", rd_data, 12'(12'h800 + j));
        end
    endtask

    task automatic t_clock_stop();
        rd_half = 3.5;
        for (int k = 0; k < 20; k++) wr_cycle(1, k == 0, 12'(12'h700 + k));
        wr_run = 0;
        for (int k = 0; k < 10; k++) rd_cycle(1, k == 0, "R8 reads while write clock halted");
        rd_run = 0;
        #137;
        wr_run = 1;
        for (int k = 20; k < 30; k++) wr_cycle(1, 0, 12'(12'h700 + k));
        #53;
        rd_run = 1;
        rd_cycle(0, 0, "R8 output kept over halt");
        chk("R8 held value", rd_data, 12'h709);
        for (int k = 10; k < 30; k++) begin
            rd_cycle(1, 0, "R8 resumed reads");
            chk("R8 resumed word", rd_data, 12'(12'h700 + k));
        end
        rd_half = 2.5;
    endtask

    initial begin
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk); wr_rst = 0;
        @(negedge rd_clk); rd_rst = 0;
        #1;
        t_reset();
        t_enable_gate();
        t_restart_idle();
        t_wrap();
        t_delay();
        t_clock_stop();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule